// File: doc/BRIEF.md
# Cascadable Serial Bitstream Store

This block holds a configuration bitstream and presents it one bit per clock to a device that is being configured. A pointer walks the stored bits from position 0 upward on each rising clock edge while the block is selected. The data pin is modelled as a value plus a drive-enable, so several instances can share one line. When the last bit has been consumed, the block releases the line and pulls its chain-select output low. That output feeds the chip enable of the next store in a chain, so a long bitstream can be split across several instances.

A single pin serves both as the pointer reset and as the output enable. Its active level is chosen by a stored polarity bit. With the default setting of 0, a high level resets the pointer and a low level enables the output. With the bit set to 1, those levels are swapped. While the serial-mode input is low, the block is in load mode: the read path is frozen, and a synchronous write port fills the bit array and the polarity bit. A power-on reset clears the pointer and the polarity bit.

Top module: `cfg_stream_mem`

## Requirements
- R1: In read mode (ser_mode=1, por_n=1), with ce_n=0, the reset/enable pin at its enabling level and pointer below DEPTH, each rising clock edge advances the pointer by one; dout shows the stored bit at the pointer without a register stage.
- R2: dout_en is 1 only when por_n=1, ser_mode=1, ce_n=0, the reset/enable pin is at its enabling level and the pointer is below DEPTH; whenever dout_en is 0, dout is 0.
- R3: In read mode, a clock edge that sees the reset/enable pin at its reset level sets the pointer to 0, whatever ce_n is, and takes precedence over an advance in the same edge.
- R4: Polarity bit 0 (default after power-on) makes rst_oe=1 the reset level and rst_oe=0 the enabling level; polarity bit 1 makes rst_oe=0 the reset level and rst_oe=1 the enabling level.
- R5: While ce_n=1, the pointer holds and dout_en is 0, at either level of rst_oe that is not the reset level.
- R6: After DEPTH bits have been read, the pointer stays at DEPTH without wrapping until a reset, and dout_en is 0.
- R7: cas_n is 0 exactly while the pointer is at DEPTH, ce_n=0, the pin is at its enabling level and ser_mode=1. cas_n therefore follows ce_n after the hand-off. Once a reset clears the pointer, cas_n stays 1 until the whole array has been read again.
- R8: While ser_mode=0, the pointer holds, dout_en is 0, cas_n is 1, and a clock edge with ld_we=1 stores ld_bit at ld_addr, and with ld_pol_we=1 stores ld_pol as the polarity bit.
- R9: While ser_mode=1, ld_we and ld_pol_we have no effect on the stored bits or the polarity.
- R10: While por_n=0, the pointer and the polarity bit clear on the clock edge, dout_en is 0 and cas_n is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Read and load clock |
| por_n | input | 1 | Power-on reset, active low, synchronous |
| ce_n | input | 1 | Chip enable, active low |
| rst_oe | input | 1 | Combined pointer reset / output enable, polarity set by stored bit |
| ser_mode | input | 1 | 1 selects read mode, 0 selects load mode |
| ld_we | input | 1 | Bit array write strobe (load mode only) |
| ld_addr | input | $clog2(DEPTH) | Bit array write position |
| ld_bit | input | 1 | Bit array write value |
| ld_pol_we | input | 1 | Polarity bit write strobe (load mode only) |
| ld_pol | input | 1 | Polarity value: 0 reset high, 1 reset low |
| dout | output | 1 | Serial data value |
| dout_en | output | 1 | Data line drive enable |
| cas_n | output | 1 | Cascade enable to the next store, active low |

## Verification
Two cascaded instances run side by side. The first instance's cas_n drives the second one's ce_n. A behavioural model with integer pointers is compared against both instances on every cycle, including a check that the two never drive the line at the same time.

Two events can fall in the same edge: a pointer reset and a pointer advance. Similarly, the hand-off to the next store can fall in the same cycle as a change of ce_n or of the enable pin. The bench provokes both. It asserts the reset level while the block is selected and in mid-stream, and also while ce_n is high. It also toggles ce_n and the enable pin after the hand-off. The model judges these cases from the stated precedence: reset wins, and cas_n follows ce_n only while the pin enables.

// File: rtl/cfg_stream_mem.sv
module cfg_stream_mem #(
  parameter int DEPTH = 256,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int PW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          por_n,
  input  logic          ce_n,
  input  logic          rst_oe,
  input  logic          ser_mode,
  input  logic          ld_we,
  input  logic [AW-1:0] ld_addr,
  input  logic          ld_bit,
  input  logic          ld_pol_we,
  input  logic          ld_pol,
  output logic          dout,
  output logic          dout_en,
  output logic          cas_n
);

  logic [DEPTH-1:0] bits_q;
  logic [PW-1:0]    ptr_q;
  logic             pol_q;

  logic rst_hit, end_hit, sel;

  assign rst_hit = pol_q ? ~rst_oe : rst_oe;
  assign end_hit = (ptr_q == PW'(DEPTH));
  assign sel     = por_n & ser_mode & ~ce_n & ~rst_hit;

  assign dout_en = sel & ~end_hit;
  assign dout    = dout_en & bits_q[ptr_q[AW-1:0]];
  assign cas_n   = ~(sel & end_hit);

  always_ff @(posedge clk) begin
    if (!por_n) begin
      ptr_q <= '0;
      pol_q <= 1'b0;
    end else if (ser_mode) begin
      if (rst_hit)
        ptr_q <= '0;
      else if (!ce_n && !end_hit)
        ptr_q <= ptr_q + PW'(1);
    end else if (ld_pol_we) begin
      pol_q <= ld_pol;
    end
  end

  always_ff @(posedge clk) begin
    if (por_n && !ser_mode && ld_we)
      bits_q[ld_addr] <= ld_bit;
  end

endmodule

// File: rtl/cfg_stream_mem_chk.sv
module cfg_stream_mem_chk #(
  parameter int DEPTH = 256,
  localparam int PW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          por_n,
  input logic          ce_n,
  input logic          rst_oe,
  input logic          ser_mode,
  input logic          dout,
  input logic          dout_en,
  input logic          cas_n,
  input logic [PW-1:0] ptr_q,
  input logic          pol_q
);

  logic rst_lvl;
  assign rst_lvl = pol_q ? ~rst_oe : rst_oe;

  // R1
  advance_step_chk: assert property (@(posedge clk) disable iff (!por_n)
    (ser_mode && !ce_n && !rst_lvl && ptr_q < PW'(DEPTH)) |=> (ptr_q == $past(ptr_q) + PW'(1)));

  // R2
  drive_needs_select_chk: assert property (@(posedge clk) disable iff (!por_n)
    dout_en |-> (!ce_n && ser_mode));

  // R2
  quiet_low_chk: assert property (@(posedge clk) disable iff (!por_n)
    !dout_en |-> !dout);

  // R3
  reset_clears_chk: assert property (@(posedge clk) disable iff (!por_n)
    (ser_mode && rst_lvl) |=> (ptr_q == '0));

  // R5
  ce_hold_chk: assert property (@(posedge clk) disable iff (!por_n)
    (ser_mode && ce_n && !rst_lvl) |=> $stable(ptr_q));

  // R6
  no_wrap_chk: assert property (@(posedge clk) disable iff (!por_n)
    ptr_q <= PW'(DEPTH));

  // R7
  handoff_exclusive_chk: assert property (@(posedge clk) disable iff (!por_n)
    !cas_n |-> (!dout_en && ptr_q == PW'(DEPTH)));

  // R8
  load_freeze_chk: assert property (@(posedge clk) disable iff (!por_n)
    !ser_mode |=> $stable(ptr_q));

  // R8
  load_silent_chk: assert property (@(posedge clk) disable iff (!por_n)
    !ser_mode |-> (!dout_en && cas_n));

endmodule

bind cfg_stream_mem cfg_stream_mem_chk #(.DEPTH(DEPTH)) chk_i (
  .clk(clk), .por_n(por_n), .ce_n(ce_n), .rst_oe(rst_oe), .ser_mode(ser_mode),
  .dout(dout), .dout_en(dout_en), .cas_n(cas_n), .ptr_q(ptr_q), .pol_q(pol_q)
);

// File: tb/cfg_stream_mem_tb_top.sv
module cfg_stream_mem_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int D = 16;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic por_n, ce_a, rst_oe, ser, we_a, we_b, pwe_a, pwe_b, ld_bit, ld_pol;
  logic [3:0] ld_addr;
  logic dout_a, en_a, cas_a, dout_b, en_b, cas_b;

  cfg_stream_mem #(.DEPTH(D)) dut_i (
    .clk(clk), .por_n(por_n), .ce_n(ce_a), .rst_oe(rst_oe), .ser_mode(ser),
    .ld_we(we_a), .ld_addr(ld_addr), .ld_bit(ld_bit), .ld_pol_we(pwe_a), .ld_pol(ld_pol),
    .dout(dout_a), .dout_en(en_a), .cas_n(cas_a));

  cfg_stream_mem #(.DEPTH(D)) dut_b_i (
    .clk(clk), .por_n(por_n), .ce_n(cas_a), .rst_oe(rst_oe), .ser_mode(ser),
    .ld_we(we_b), .ld_addr(ld_addr), .ld_bit(ld_bit), .ld_pol_we(pwe_b), .ld_pol(ld_pol),
    .dout(dout_b), .dout_en(en_b), .cas_n(cas_b));

  int pa, pb;
  bit pola, polb;
  bit [D-1:0] ma, mb;
  int n_chk = 0, n_fail = 0;
  string req = "R10";
  localparam bit [D-1:0] PAT_A = 16'hA53C;
  localparam bit [D-1:0] PAT_B = 16'h3C96;

  function automatic bit rhit(bit pol);
    return pol ? !rst_oe : rst_oe;
  endfunction

  function automatic bit m_sel(bit pol, bit ce);
    return por_n && ser && !ce && !rhit(pol);
  endfunction

  task automatic chk(string r, logic act, logic exp, string what);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%b expected=%b t=%0t", r, what, act, exp, $time);
    end
  endtask

  task automatic cyc();
    bit ca, ea, eb;
    @(negedge clk);
    ca = !(m_sel(pola, ce_a) && pa == D);
    ea = m_sel(pola, ce_a) && pa < D;
    eb = m_sel(polb, ca) && pb < D;
    chk(req, en_a, ea, "A dout_en");
    chk(req, dout_a, ea ? ma[pa] : 1'b0, "A dout");
    chk(req, cas_a, ca, "A cas_n");
    chk(req, en_b, eb, "B dout_en");
    chk(req, dout_b, eb ? mb[pb] : 1'b0, "B dout");
    chk(req, cas_b, !(m_sel(polb, ca) && pb == D), "B cas_n");
    chk("R7", en_a & en_b, 1'b0, "single driver");
    @(posedge clk);
    if (!por_n) begin
      pa = 0; pola = 0; pb = 0; polb = 0;
    end else if (ser) begin
      if (rhit(pola)) pa = 0; else if (!ce_a && pa < D) pa++;
      if (rhit(polb)) pb = 0; else if (!ca && pb < D) pb++;
    end else begin
      if (we_a) ma[ld_addr] = ld_bit;
      if (we_b) mb[ld_addr] = ld_bit;
      if (pwe_a) pola = ld_pol;
      if (pwe_b) polb = ld_pol;
    end
    #1;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    pa = 0; pb = 0; pola = 0; polb = 0; ma = '0; mb = '0;
    por_n = 0; ser = 0; ce_a = 0; rst_oe = 0; we_a = 0; we_b = 0;
    pwe_a = 0; pwe_b = 0; ld_bit = 0; ld_pol = 0; ld_addr = '0;
    req = "R10"; repeat (2) cyc();
    por_n = 1; req = "R8";
    for (int i = 0; i < D; i++) begin
      ld_addr = 4'(i); ld_bit = PAT_A[i]; we_a = 1; cyc();
    end
    we_a = 0;
    for (int i = 0; i < D; i++) begin
      ld_addr = 4'(i); ld_bit = PAT_B[i]; we_b = 1; cyc();
    end
    we_b = 0;
    ser = 1; rst_oe = 1; req = "R3"; cyc();
    rst_oe = 0; req = "R1"; repeat (6) cyc();
    req = "R5"; ce_a = 1; repeat (3) cyc();
    ce_a = 0; req = "R6"; repeat (D - 6 + D + 3) cyc();
    req = "R7"; ce_a = 1; repeat (2) cyc();
    ce_a = 0; cyc();
    rst_oe = 1; cyc();
    rst_oe = 0; repeat (4) cyc();
    req = "R9"; we_a = 1; ld_addr = 0; ld_bit = !PAT_A[0]; pwe_a = 1; ld_pol = 1; cyc();
    we_a = 0; pwe_a = 0; rst_oe = 1; cyc();
    rst_oe = 0; repeat (3) cyc();
    req = "R3"; ce_a = 1; rst_oe = 1; cyc();
    rst_oe = 0; cyc(); ce_a = 0; repeat (5) cyc();
    rst_oe = 1; cyc(); rst_oe = 0; repeat (3) cyc();
    req = "R8"; ser = 0; repeat (3) cyc();
    ser = 1; repeat (2) cyc();
    req = "R4"; ser = 0; pwe_a = 1; pwe_b = 1; ld_pol = 1; cyc();
    pwe_a = 0; pwe_b = 0; ser = 1; rst_oe = 0; repeat (2) cyc();
    rst_oe = 1; repeat (D + D + 2) cyc();
    req = "R7"; ce_a = 1; cyc(); ce_a = 0; cyc();
    rst_oe = 0; cyc(); rst_oe = 1; repeat (3) cyc();
    req = "R10"; por_n = 0; repeat (2) cyc();
    por_n = 1; rst_oe = 0; repeat (3) cyc();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule